// File: doc/BRIEF.md
# Two-Bit Branch History Table

This block predicts the direction of conditional branches. It keeps a table of 2048 two-bit saturating counters and selects an entry with a slice of the fetch address just above the instruction-alignment bits. A fetch-stage lookup returns the counter and the direction it implies one cycle later, so the value can travel with the instruction to decode.

When a branch resolves, the pipeline sends back the branch address and the real outcome. The block moves that entry's counter one step toward the outcome. One cycle later it reports whether the entry's direction before the update disagreed with the outcome, so the pipeline can flush.

No tag is stored. Every branch whose index bits match shares one counter. This aliasing can cost accuracy, but it can never cause incorrect execution. Because the counters saturate, a strongly held direction changes only after two consecutive wrong outcomes.

Top module: `bht_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken). A lookup of any address then reports state 01 and not-taken.
- R2: The reported direction is bit 1 of the counter. States 11 and 10 mean taken, and states 01 and 00 mean not taken.
- R3: An update with outcome taken adds one to the counter, and the counter stays at 11 once it reaches 11.
- R4: An update with outcome not-taken subtracts one from the counter, and the counter stays at 00 once it reaches 00.
- R5: From a strong state (11 or 00), one opposite outcome leaves the predicted direction unchanged. A second consecutive opposite outcome flips it.
- R6: The entry index is address bits [12:2]. Address bits above 12 and the two bits below bit 2 do not select an entry, so addresses that differ only in those bits share one counter.
- R7: One cycle after an update, misp_valid is 1 and mispredict is 1 exactly when bit 1 of the counter before the update differs from the outcome. misp_valid and mispredict are 0 in a cycle after no update.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup reports the counter as it was before that update.
- R9: pred_valid follows lk_valid with one cycle of delay. An update cycle with upd_valid low changes no counter, whatever upd_pc and upd_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address to look up |
| pred_valid | output | 1 | Lookup result present |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_state | output | 2 | Counter value read for the lookup |
| upd_valid | input | 1 | Resolved branch update this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| misp_valid | output | 1 | Mispredict flag present |
| mispredict | output | 1 | Counter direction differed from outcome |

## Verification
Both results arrive exactly one clock edge after the request. The prediction triple appears after the edge that samples lk_valid. The mispredict pair appears after the edge that samples upd_valid, and the counter's new value is visible to a lookup in the following cycle.

The bench drives inputs on the falling edge and samples outputs on the next falling edge. Expected values come from a model that is read before it applies the same cycle's update. This keeps the same-entry read-and-update case and all one-cycle latencies in step with the design.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef logic [1:0] bht_ctr_t;

    localparam bht_ctr_t CTR_STRONG_NT = 2'b00;
    localparam bht_ctr_t CTR_WEAK_NT   = 2'b01;
    localparam bht_ctr_t CTR_WEAK_T    = 2'b10;
    localparam bht_ctr_t CTR_STRONG_T  = 2'b11;

    // direction implied by a counter: upper bit set means taken
    function automatic logic ctr_dir(input bht_ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 11
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int TOP = PC_LSB + IDX_W;

    assign idx = pc[PC_LSB +: IDX_W];

    // bits outside the index slice take no part in selection
    generate
        if (PC_LSB > 0 && TOP < PC_W) begin : g_both
            logic unused_bits;
            assign unused_bits = ^{pc[PC_W-1:TOP], pc[PC_LSB-1:0]};
        end else if (PC_LSB > 0) begin : g_low
            logic unused_bits;
            assign unused_bits = ^pc[PC_LSB-1:0];
        end else if (TOP < PC_W) begin : g_high
            logic unused_bits;
            assign unused_bits = ^pc[PC_W-1:TOP];
        end
    endgenerate
endmodule

// File: rtl/bht_counter.sv
module bht_counter
    import bht_pkg::*;
(
    input  bht_ctr_t cur,
    input  logic     taken,
    output bht_ctr_t nxt,
    output logic     dir
);
    always_comb begin
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
    end

    assign dir = ctr_dir(cur);
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_valid,
    output logic            pred_taken,
    output logic [1:0]      pred_state,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            misp_valid,
    output logic            mispredict
);
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic     pred_vld;
        logic     pred_tkn;
        bht_ctr_t pred_ctr;
        logic     misp_vld;
        logic     misp;
    } out_t;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        bht_ctr_t         val;
    } wr_t;

    bht_ctr_t         tbl_q [ENTRIES];
    out_t             out_d, out_q;
    wr_t              wr_d;
    logic [IDX_W-1:0] lk_idx, up_idx;
    bht_ctr_t         lk_ctr, up_ctr, up_nxt;
    logic             up_dir;

    bht_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W)) u_lk_idx (
        .pc (lk_pc),
        .idx(lk_idx)
    );

    bht_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W)) u_up_idx (
        .pc (upd_pc),
        .idx(up_idx)
    );

    assign lk_ctr = tbl_q[lk_idx];
    assign up_ctr = tbl_q[up_idx];

    bht_counter u_ctr (
        .cur  (up_ctr),
        .taken(upd_taken),
        .nxt  (up_nxt),
        .dir  (up_dir)
    );

    // next values: the lookup reads the table before this edge's write
    always_comb begin
        out_d = '0;
        wr_d  = '0;
        if (lk_valid) begin
            out_d.pred_vld = 1'b1;
            out_d.pred_ctr = lk_ctr;
            out_d.pred_tkn = ctr_dir(lk_ctr);
        end
        if (upd_valid) begin
            out_d.misp_vld = 1'b1;
            out_d.misp     = up_dir ^ upd_taken;
            wr_d.we        = 1'b1;
            wr_d.idx       = up_idx;
            wr_d.val       = up_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i] <= CTR_WEAK_NT;
            end
        end else begin
            out_q <= out_d;
            if (wr_d.we) begin
                tbl_q[wr_d.idx] <= wr_d.val;
            end
        end
    end

    assign pred_valid = out_q.pred_vld;
    assign pred_taken = out_q.pred_tkn;
    assign pred_state = out_q.pred_ctr;
    assign misp_valid = out_q.misp_vld;
    assign mispredict = out_q.misp;
endmodule

// File: rtl/bht_predictor_chk.sv
module bht_predictor_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [PC_W-1:0] lk_pc,
    input logic            pred_valid,
    input logic            pred_taken,
    input logic [1:0]      pred_state,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken,
    input logic            misp_valid,
    input logic            mispredict
);
    AST_PRED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> pred_valid); // R9
    AST_PRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !pred_valid); // R9
    AST_PRED_DIR: assert property (@(posedge clk) disable iff (!rst_n) pred_valid |-> (pred_taken == pred_state[1])); // R2
    AST_MISP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) upd_valid |=> misp_valid); // R7
    AST_MISP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !misp_valid |-> !mispredict); // R7
    AST_SAME_ENTRY_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && upd_valid && lk_pc == upd_pc) |=> (mispredict == (pred_taken ^ $past(upd_taken)))); // R8
endmodule

bind bht_predictor bht_predictor_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_state(pred_state),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .misp_valid(misp_valid), .mispredict(mispredict)
);

// File: tb/bht_predictor_test.sv
module bht_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int ENT        = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        pred_valid, pred_taken;
    logic [1:0]  pred_state;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        misp_valid, mispredict;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [1:0] mdl [ENT];

    always #(CLK_PERIOD/2) clk = ~clk;

    bht_predictor uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_state(pred_state),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .misp_valid(misp_valid), .mispredict(mispredict)
    );

    function automatic int m_idx(input logic [31:0] pc);
        return int'(pc[12:2]);
    endfunction

    function automatic logic [1:0] m_next(input logic [1:0] c, input logic t);
        if (t) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic cyc(input logic lv, input logic [31:0] lpc,
                       input logic uv, input logic [31:0] upc, input logic ut,
                       input string req);
        logic [1:0] e_st;
        logic       e_m;
        lk_valid = lv; lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
        e_st = mdl[m_idx(lpc)];
        e_m  = mdl[m_idx(upc)][1] ^ ut;
        @(negedge clk);
        chk({req, "/R9 pred_valid"}, {31'd0, pred_valid}, {31'd0, lv});
        chk("R7 misp_valid", {31'd0, misp_valid}, {31'd0, uv});
        if (lv) begin
            chk({req, " state"}, {30'd0, pred_state}, {30'd0, e_st});
            chk("R2 direction", {31'd0, pred_taken}, {31'd0, e_st[1]});
        end
        if (uv) chk("R7 mispredict", {31'd0, mispredict}, {31'd0, e_m});
        else    chk("R7 idle flag", {31'd0, mispredict}, 32'd0);
        if (uv) mdl[m_idx(upc)] = m_next(mdl[m_idx(upc)], ut);
    endtask

    task automatic upd(input logic [31:0] pc, input logic t, input string req);
        cyc(1'b0, 32'd0, 1'b1, pc, t, req);
    endtask

    task automatic look(input logic [31:0] pc, input string req);
        cyc(1'b1, pc, 1'b0, 32'd0, 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENT; i++) mdl[i] = 2'b01;
        void'($urandom(32'h5EED_0B47));
        repeat (3) @(negedge clk);
        chk("R1 reset pred_valid", {31'd0, pred_valid}, 32'd0);
        chk("R1 reset misp_valid", {31'd0, misp_valid}, 32'd0);
        rst_n = 1'b1;

        // R1: reset state everywhere
        look(32'h0000_0000, "R1");
        look(32'h1234_5678, "R1");
        look(32'hFFFF_FFFC, "R1");

        // R3: climb and saturate at 11
        upd(32'h100, 1'b1, "R3"); look(32'h100, "R3");
        upd(32'h100, 1'b1, "R3"); look(32'h100, "R3");
        chk("R3 at strong taken", {30'd0, pred_state}, 32'd3);
        upd(32'h100, 1'b1, "R3"); look(32'h100, "R3");
        chk("R3 saturated", {30'd0, pred_state}, 32'd3);

        // R5: one miss keeps taken, second miss flips
        upd(32'h100, 1'b0, "R5"); look(32'h100, "R5");
        chk("R5 still taken", {31'd0, pred_taken}, 32'd1);
        upd(32'h100, 1'b0, "R5"); look(32'h100, "R5");
        chk("R5 flipped", {31'd0, pred_taken}, 32'd0);

        // R4: descend and saturate at 00
        upd(32'h100, 1'b0, "R4"); upd(32'h100, 1'b0, "R4"); look(32'h100, "R4");
        chk("R4 saturated", {30'd0, pred_state}, 32'd0);

        // R7: from 00 a taken outcome mispredicts, then from 01 not-taken does not
        upd(32'h100, 1'b1, "R7");
        chk("R7 miss seen", {31'd0, mispredict}, 32'd1);
        upd(32'h100, 1'b0, "R7");
        chk("R7 hit seen", {31'd0, mispredict}, 32'd0);

        // R6: aliasing on index bits only
        upd(32'h200, 1'b1, "R6");
        look(32'hABC0_0203, "R6");
        chk("R6 alias shares", {30'd0, pred_state}, 32'd2);
        look(32'h204, "R6");
        chk("R6 neighbour untouched", {30'd0, pred_state}, 32'd1);

        // R8: same entry read and written in one cycle
        cyc(1'b1, 32'h300, 1'b1, 32'h300, 1'b1, "R8");
        chk("R8 pre-update value", {30'd0, pred_state}, 32'd1);
        look(32'h300, "R8");
        chk("R8 post-update value", {30'd0, pred_state}, 32'd2);

        // R9: update fields with valid low change nothing
        cyc(1'b0, 32'd0, 1'b0, 32'h400, 1'b1, "R9");
        cyc(1'b0, 32'd0, 1'b0, 32'h400, 1'b1, "R9");
        look(32'h400, "R9");
        chk("R9 no write", {30'd0, pred_state}, 32'd1);

        // random traffic on a few hot indices with varied alias bits
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a, b;
            a = ($urandom() & 32'hFFFF_E003) | (($urandom() % 8) << 2);
            b = ($urandom() % 4 == 0) ? a :
                (($urandom() & 32'hFFFF_E003) | (($urandom() % 8) << 2));
            cyc(1'($urandom() % 4 != 0), a, 1'($urandom() % 3 != 0), b, 1'($urandom()), "R6");
        end
        cyc(1'b0, 32'd0, 1'b0, 32'd0, 1'b0, "R9");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule